// File: doc/BRIEF.md
# Erase/Write Cycle Sequencer

This block times the internal non-volatile programming cycle of a small serial memory once the bus controller has finished taking in a write transfer. The controller pulses a start input on the stop condition that closes the transfer, together with a page-mode flag and the index of the last latched byte. From then on the sequencer holds a busy flag and walks through a fixed set of slots. For each slot it drives an erase strobe or a write strobe, and a byte index that tells the cell array which latched byte to program. One extra tick at the end produces a single-cycle done pulse and drops busy.

There are two slot layouts. In byte mode every latched byte gets its own slot of 2·2^HALF_LOG ticks: half erase, half write. In page mode a single erase slot of 2^HALF_LOG ticks is followed by 2^IDX_W write slots of the same length. Ticks come from one of two sources. The internal one is a prescaled oscillator enable divided by DIV inside the block. The external one is a clock pin that has been synchronised and edge-detected upstream. Which source is used is latched when the controller strobes a sample input at the bus bit where the programming pin is examined: a low pin picks the external clock. While busy, the block ignores start and sample strobes.

Top module: `ews_sequencer`

## Requirements
- R1: While rst_n is low at a clock edge, the block returns to idle: busy_o, erase_o, write_o and done_o are low after that edge, and the tick source goes back to internal.
- R2: A start_i pulse sampled while idle makes busy_o high from the next cycle.
- R3: In byte mode (page_mode_i = 0) with last_idx_i = k, the cycle lasts (k+1)·256+1 ticks at the default HALF_LOG = 7, so 257 ticks for one byte and 513 ticks for two.
- R4: In byte mode, byte j (0 to k, in ascending order) is erased for 128 ticks and then written for 128 ticks, with byte_idx_o = j during both phases.
- R5: In page mode (page_mode_i = 1) the cycle lasts 1153 ticks. The first 128 ticks are erase with byte_idx_o = 0, then bytes 0 to 7 are each written for 128 ticks in ascending order. last_idx_i has no effect.
- R6: The last tick of a cycle drives neither strobe. done_o is high for exactly one cycle, the first cycle in which busy_o is low again.
- R7: With the internal source, one tick is taken for every DIV cycles in which osc_en_i is high while busy. The divider restarts at every cycle start.
- R8: A src_sample_i strobe while idle selects the external source when ptc_level_i is 0 and the internal source when it is 1. The choice holds across cycles. With the external source, osc_en_i does not advance the cycle, and one tick is taken per ext_tick_i cycle while busy.
- R9: While busy, start_i, src_sample_i, page_mode_i and last_idx_i are ignored. The running cycle keeps its length and layout, and the tick source is unchanged.
- R10: erase_o and write_o are never high together, and neither is high unless busy_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Single-cycle request to begin a programming cycle |
| page_mode_i | input | 1 | 1 selects the page layout, 0 the per-byte layout |
| last_idx_i | input | IDX_W | Index of the last latched byte (byte count minus one) |
| src_sample_i | input | 1 | Strobe that latches the tick-source choice |
| ptc_level_i | input | 1 | Programming pin level; 0 at the sample strobe selects the external clock |
| osc_en_i | input | 1 | Prescaled oscillator enable feeding the internal divider |
| ext_tick_i | input | 1 | One-cycle pulse per external programming clock period |
| busy_o | output | 1 | High for the whole programming cycle |
| erase_o | output | 1 | Erase phase strobe |
| write_o | output | 1 | Write phase strobe |
| byte_idx_o | output | IDX_W | Latched byte being erased or written |
| done_o | output | 1 | Single-cycle pulse at the end of a cycle |

## Verification
The cycle is driven in both layouts with every byte count, and each cycle is measured in source pulses per phase and per byte index. This separates a wrong slot length from a wrong byte ordering and from the page layout's single erase. The internal source is run with a steady and a randomly gated oscillator enable, which tells the divider ratio apart from a count of clock cycles. The external source is run at random pulse spacings, and in one case held without pulses to show that the oscillator does not leak into it. Starts, mode changes and source strobes injected mid-cycle, together with a reset during a cycle, show whether busy-time inputs really leave the running cycle and the later source choice alone.

// File: rtl/ews_pkg.sv
// Shared helpers for the erase/write cycle sequencer.
// Assumes: half-slot and page sizes are powers of two.
package ews_pkg;

    typedef enum logic { SRC_INT = 1'b0, SRC_EXT = 1'b1 } ews_src_e;

    // Number of strobe-carrying ticks in one cycle (the closing tick is extra).
    function automatic int cycle_ticks(input logic page, input int last,
                                       input int half_log, input int idx_w);
        if (page)
            return ((1 << idx_w) + 1) << half_log;
        return (last + 1) << (half_log + 1);
    endfunction

endpackage

// File: rtl/ews_tick_src.sv
// Tick source: latches the clock-source choice and divides the oscillator
// enable. Assumes ext_tick_i is already a synchronous single-cycle pulse.
module ews_tick_src #(
    parameter int DIV = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic busy,
    input  logic src_sample_i,
    input  logic ptc_level_i,
    input  logic osc_en_i,
    input  logic ext_tick_i,
    output logic tick,
    output ews_pkg::ews_src_e src
);
    localparam int DIV_W = (DIV > 1) ? $clog2(DIV) : 1;

    logic [DIV_W-1:0] div_q;
    logic             int_tick;

    // Latch the source choice only while idle; a low pin means external.
    always_ff @(posedge clk) begin
        if (!rst_n)
            src <= ews_pkg::SRC_INT;
        else if (src_sample_i && !busy)
            src <= ptc_level_i ? ews_pkg::SRC_INT : ews_pkg::SRC_EXT;
    end

    // Oscillator divider, held cleared while idle so each cycle starts aligned.
    always_ff @(posedge clk) begin
        if (!rst_n || !busy)
            div_q <= '0;
        else if (osc_en_i)
            div_q <= (div_q == DIV_W'(DIV - 1)) ? '0 : div_q + 1'b1;
    end

    // Select the tick that advances the cycle.
    always_comb begin
        int_tick = busy && osc_en_i && (div_q == DIV_W'(DIV - 1));
        tick     = (src == ews_pkg::SRC_EXT) ? (busy && ext_tick_i) : int_tick;
    end

endmodule

// File: rtl/ews_slot_timer.sv
// Slot timer: holds busy, counts ticks up to the latched total, then spends
// one more tick to raise done. Assumes total_i is sampled only on start.
module ews_slot_timer #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             page_i,
    input  logic [CNT_W-1:0] total_i,
    input  logic             tick,
    output logic             busy,
    output logic             done,
    output logic             page_q,
    output logic [CNT_W-1:0] tcnt,
    output logic [CNT_W-1:0] total_q
);

    // Cycle control: launch on start while idle, advance on tick, close at total.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            done    <= 1'b0;
            page_q  <= 1'b0;
            tcnt    <= '0;
            total_q <= '0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (start_i) begin
                    busy    <= 1'b1;
                    tcnt    <= '0;
                    total_q <= total_i;
                    page_q  <= page_i;
                end
            end else if (tick) begin
                if (tcnt == total_q) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end else begin
                    tcnt <= tcnt + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/ews_strobe_dec.sv
// Strobe decoder: maps the tick count onto erase/write phases and a byte
// index for either slot layout. Purely combinational.
module ews_strobe_dec #(
    parameter int HALF_LOG = 7,
    parameter int IDX_W    = 3,
    parameter int CNT_W    = HALF_LOG + IDX_W + 2
) (
    input  logic             busy,
    input  logic             page_q,
    input  logic [CNT_W-1:0] tcnt,
    input  logic [CNT_W-1:0] total_q,
    output logic             erase,
    output logic             write,
    output logic [IDX_W-1:0] idx
);
    localparam int SLOT_W = CNT_W - HALF_LOG;

    logic              active;
    logic [SLOT_W-1:0] slot;

    // Page layout uses half-slots as whole slots; byte layout pairs them.
    always_comb begin
        active = busy && (tcnt != total_q);
        slot   = tcnt[CNT_W-1:HALF_LOG];
        if (page_q) begin
            erase = active && (slot == '0);
            write = active && (slot != '0);
            idx   = (slot == '0) ? '0 : IDX_W'(slot - 1'b1);
        end else begin
            erase = active && !tcnt[HALF_LOG];
            write = active && tcnt[HALF_LOG];
            idx   = tcnt[HALF_LOG+1 +: IDX_W];
        end
    end

endmodule

// File: rtl/ews_sequencer.sv
// Erase/write cycle sequencer top: joins tick source, slot timer and strobe
// decoder. Assumes start_i arrives on the stop of a valid write transfer.
module ews_sequencer #(
    parameter int HALF_LOG = 7,
    parameter int IDX_W    = 3,
    parameter int DIV      = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             page_mode_i,
    input  logic [IDX_W-1:0] last_idx_i,
    input  logic             src_sample_i,
    input  logic             ptc_level_i,
    input  logic             osc_en_i,
    input  logic             ext_tick_i,
    output logic             busy_o,
    output logic             erase_o,
    output logic             write_o,
    output logic [IDX_W-1:0] byte_idx_o,
    output logic             done_o
);
    localparam int CNT_W = HALF_LOG + IDX_W + 2;

    logic              tick;
    logic              src_ext;
    logic              page_q;
    logic [CNT_W-1:0]  tcnt;
    logic [CNT_W-1:0]  total_q;
    logic [CNT_W-1:0]  total_in;
    ews_pkg::ews_src_e src;

    // Cycle length requested by the current inputs.
    always_comb begin
        total_in = CNT_W'(ews_pkg::cycle_ticks(page_mode_i, int'(last_idx_i),
                                                HALF_LOG, IDX_W));
        src_ext  = (src == ews_pkg::SRC_EXT);
    end

    ews_tick_src #(.DIV(DIV)) u_src (
        .clk(clk), .rst_n(rst_n), .busy(busy_o),
        .src_sample_i(src_sample_i), .ptc_level_i(ptc_level_i),
        .osc_en_i(osc_en_i), .ext_tick_i(ext_tick_i),
        .tick(tick), .src(src)
    );

    ews_slot_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .page_i(page_mode_i),
        .total_i(total_in), .tick(tick), .busy(busy_o), .done(done_o),
        .page_q(page_q), .tcnt(tcnt), .total_q(total_q)
    );

    ews_strobe_dec #(.HALF_LOG(HALF_LOG), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_dec (
        .busy(busy_o), .page_q(page_q), .tcnt(tcnt), .total_q(total_q),
        .erase(erase_o), .write(write_o), .idx(byte_idx_o)
    );

endmodule

// File: rtl/ews_seq_checker.sv
// Protocol checker for the sequencer ports; attached by bind below.
module ews_seq_checker (
    input logic clk,
    input logic rst_n,
    input logic start_i,
    input logic busy_o,
    input logic erase_o,
    input logic write_o,
    input logic done_o,
    input logic src_ext
);
    a_r10_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(erase_o && write_o));

    a_r10_strobe_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_o || write_o) |-> busy_o);

    a_r2_start_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);

    a_r6_done_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $past(busy_o)));

    a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r9_src_held: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> $stable(src_ext));
endmodule

bind ews_sequencer ews_seq_checker u_chk (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy_o),
    .erase_o(erase_o), .write_o(write_o), .done_o(done_o), .src_ext(src_ext)
);

// File: tb/ews_sequencer_bench.sv
module ews_sequencer_bench;
    localparam int DIV = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0, page_mode_i = 1'b0, src_sample_i = 1'b0;
    logic ptc_level_i = 1'b1, osc_en_i = 1'b0, ext_tick_i = 1'b0;
    logic [2:0] last_idx_i = '0;
    logic busy_o, erase_o, write_o, done_o;
    logic [2:0] byte_idx_o;

    int checks = 0, fails = 0;
    bit finished = 0;
    bit osc_rand = 0, ext_run = 0;
    int ext_per = 3, ext_cnt = 0;

    always #10 clk = ~clk;

    ews_sequencer #(.DIV(DIV)) u_ews_sequencer (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .page_mode_i(page_mode_i),
        .last_idx_i(last_idx_i), .src_sample_i(src_sample_i),
        .ptc_level_i(ptc_level_i), .osc_en_i(osc_en_i), .ext_tick_i(ext_tick_i),
        .busy_o(busy_o), .erase_o(erase_o), .write_o(write_o),
        .byte_idx_o(byte_idx_o), .done_o(done_o)
    );

    // Oscillator enable and external clock pulse generator.
    initial forever begin
        @(posedge clk); #1;
        osc_en_i = osc_rand ? 1'($urandom % 2) : 1'b1;
        if (ext_run) begin
            ext_cnt    = (ext_cnt + 1) % ext_per;
            ext_tick_i = (ext_cnt == 0);
        end else ext_tick_i = 1'b0;
    end

    function automatic int exp_total(bit page, int last);
        return page ? 9 * 128 + 1 : (last + 1) * 256 + 1;
    endfunction
    function automatic int exp_erase(bit page, int last);
        return page ? 128 : (last + 1) * 128;
    endfunction
    function automatic int exp_write(bit page, int last, int k);
        return (page || k <= last) ? 128 : 0;
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic select_src(bit ext);
        @(posedge clk); #1;
        src_sample_i = 1'b1; ptc_level_i = ext ? 1'b0 : 1'b1;
        @(posedge clk); #1;
        src_sample_i = 1'b0; ptc_level_i = 1'b1;
    endtask

    // One full cycle; counts source pulses per phase and index.
    task automatic run_cycle(bit page, int last, bit ext, bit disturb);
        int u, tot, er, wr[8], it;
        bit order_ok, seen_write, done_ok;
        int prev_idx;
        u = ext ? 1 : DIV;
        tot = 0; er = 0; order_ok = 1; seen_write = 0; prev_idx = 0;
        foreach (wr[k]) wr[k] = 0;
        @(posedge clk); #1;
        start_i = 1'b1; page_mode_i = page; last_idx_i = 3'(last);
        @(posedge clk); #1;
        start_i = 1'b0;
        check(busy_o == 1'b1, "R2", "busy after start", int'(busy_o), 1);
        it = 0;
        forever begin
            @(negedge clk);
            if (!busy_o) break;
            if (it == 40 && disturb) begin
                start_i = 1'b1; page_mode_i = ~page; last_idx_i = 3'($urandom);
                src_sample_i = 1'b1; ptc_level_i = ext ? 1'b1 : 1'b0;
            end else if (it == 41 && disturb) begin
                start_i = 1'b0; src_sample_i = 1'b0; ptc_level_i = 1'b1;
            end
            if (ext ? ext_tick_i : osc_en_i) begin
                tot++;
                if (erase_o) er++;
                if (write_o) wr[byte_idx_o]++;
            end
            if (page && erase_o && (seen_write || byte_idx_o != 0)) order_ok = 0;
            if (write_o || (!page && erase_o)) begin
                if (int'(byte_idx_o) < prev_idx) order_ok = 0;
                prev_idx = int'(byte_idx_o);
            end
            if (write_o) seen_write = 1;
            if (erase_o && write_o) order_ok = 0;
            it++;
            if (it > 30000) break;
        end
        check(it <= 30000, "R3", "cycle finished", it, 30000);
        done_ok = done_o;
        check(done_ok, "R6", "done with busy fall", int'(done_o), 1);
        check(tot == exp_total(page, last) * u, page ? "R5" : "R3",
              "source pulses in cycle", tot, exp_total(page, last) * u);
        check(er == exp_erase(page, last) * u, page ? "R5" : "R4",
              "erase pulses", er, exp_erase(page, last) * u);
        for (int k = 0; k < 8; k++)
            check(wr[k] == exp_write(page, last, k) * u, page ? "R5" : "R4",
                  $sformatf("write pulses idx %0d", k), wr[k],
                  exp_write(page, last, k) * u);
        check(order_ok, page ? "R5" : "R4", "phase order", int'(order_ok), 1);
        @(negedge clk);
        check(done_o == 1'b0, "R6", "done single cycle", int'(done_o), 0);
    endtask

    // Global watchdog.
    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(!busy_o && !erase_o && !write_o && !done_o, "R1", "reset outputs",
              int'({busy_o, erase_o, write_o, done_o}), 0);
        @(posedge clk); #1 rst_n = 1'b1;

        // Directed: internal source, steady oscillator (R7).
        run_cycle(1'b0, 0, 1'b0, 1'b0);
        run_cycle(1'b0, 1, 1'b0, 1'b0);
        run_cycle(1'b1, 5, 1'b0, 1'b0);
        run_cycle(1'b0, 7, 1'b0, 1'b0);
        // Gated oscillator (R7).
        osc_rand = 1;
        run_cycle(1'b0, 2, 1'b0, 1'b0);
        run_cycle(1'b1, 0, 1'b0, 1'b0);
        // Busy-time inputs ignored, source stays internal (R9).
        run_cycle(1'b0, 3, 1'b0, 1'b1);
        run_cycle(1'b1, 2, 1'b0, 1'b1);
        run_cycle(1'b0, 1, 1'b0, 1'b0);

        // External source: no pulses means no progress (R8).
        select_src(1'b1);
        osc_rand = 0;
        @(posedge clk); #1 start_i = 1'b1; page_mode_i = 1'b0; last_idx_i = 3'd0;
        @(posedge clk); #1 start_i = 1'b0;
        repeat (300) @(posedge clk);
        @(negedge clk);
        check(busy_o && erase_o, "R8", "external source stalls without pulses",
              int'({busy_o, erase_o}), 3);
        // Reset in mid-cycle (R1).
        @(posedge clk); #1 rst_n = 1'b0;
        @(posedge clk); #1 rst_n = 1'b1;
        @(negedge clk);
        check(!busy_o && !erase_o && !write_o && !done_o, "R1", "reset mid-cycle",
              int'({busy_o, erase_o, write_o, done_o}), 0);
        // Reset returned the source to internal (R1).
        run_cycle(1'b0, 0, 1'b0, 1'b0);

        // Random external runs (R8, R9).
        select_src(1'b1);
        ext_run = 1; osc_rand = 1;
        for (int n = 0; n < 6; n++) begin
            ext_per = 1 + ($urandom % 4);
            run_cycle(1'($urandom % 2), int'($urandom % 8), 1'b1, 1'($urandom % 2));
        end
        // Back to internal source (R8).
        ext_run = 0;
        select_src(1'b0);
        for (int n = 0; n < 3; n++)
            run_cycle(1'($urandom % 2), int'($urandom % 8), 1'b0, 1'($urandom % 2));

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule